// File: doc/BRIEF.md
# Configurable Registered ALU

This block is an arithmetic/logic unit meant for timing and area studies. It accepts two operands and an operation code each cycle, and returns one result with a valid flag. Operands are captured into registers on the way in and the result leaves from a register. Every internal path therefore starts and ends at a flop, which gives clean boundaries when the block is measured on its own.

A build-time mask chooses which operations exist. An operation whose mask bit is clear produces no logic, and its opcode returns zero. The three shift kinds use one barrel shifter between them. The adder can be narrowed to a smaller width. Multiplication runs in its own pipeline of configurable depth, and its results re-enter the same output register.

Top module: `cfg_alu`

## Requirements
- R1: A non-multiply operation issued with `valid_i` high at a clock edge appears on `result_o` with `valid_o` high exactly two rising edges later. Neither output changes at the first edge.
- R2: Opcode 0 (add) returns the sum of the low `ADD_W` bits of both operands, truncated to `ADD_W` bits and zero-extended to `WIDTH`.
- R3: Opcodes 1 (AND) and 2 (OR) return the bitwise result of the two operands. Opcode 3 (XOR) does the same when it is enabled.
- R4: Opcodes 4 (left shift) and 5 (logical right shift) shift operand A by the value in the low `$clog2(WIDTH)` bits of operand B, filling with zeros.
- R5: Opcode 6 (arithmetic right shift) shifts operand A right by the same amount and fills the vacated bits with bit `WIDTH-1` of A.
- R6: Opcode 7 (multiply) returns the low `WIDTH` bits of A times B, `MUL_STAGES+2` edges after issue. A new multiply can be issued every cycle.
- R7: An opcode whose bit in `OP_MASK` is clear, or any opcode from 8 to 15, returns zero with `valid_o` high after the non-multiply latency.
- R8: If a multiply result and a non-multiply result reach the output register at the same edge, the multiply result is kept and the other is discarded.
- R9: Asserting `rst_ni` low clears every operand, pipeline and result register and every valid bit. The outputs read zero.
- R10: Cycles without `valid_i` produce no `valid_o`, whatever is on the data and opcode inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation issue strobe |
| op_i | input | 4 | Operation code |
| a_i | input | WIDTH | Operand A |
| b_i | input | WIDTH | Operand B (also the shift amount) |
| valid_o | output | 1 | Result valid |
| result_o | output | WIDTH | Result |

## Verification
The bench builds the block with `WIDTH=8`, `ADD_W=4`, `MUL_STAGES=4` and XOR removed from the mask. At 8 bits, every value of operand A can be swept against a spread of B values for all sixteen opcodes, and every shift amount is covered. The narrowed adder exposes the truncation of the carry. The missing XOR and the unused opcodes show the zero result. Streams that mix operation kinds make multiply results collide with later single-cycle results at the output register. This checks the priority rule and the two latencies against each other. A reset in the middle of a run is also applied.

// File: rtl/cfg_alu_pkg.sv
package cfg_alu_pkg;
  typedef enum logic [3:0] {
    OP_ADD = 4'd0,
    OP_AND = 4'd1,
    OP_OR  = 4'd2,
    OP_XOR = 4'd3,
    OP_SHL = 4'd4,
    OP_SHR = 4'd5,
    OP_SRA = 4'd6,
    OP_MUL = 4'd7
  } alu_op_e;

  typedef enum logic [1:0] {
    SK_LEFT = 2'd0,
    SK_RLOG = 2'd1,
    SK_RARI = 2'd2
  } shift_kind_e;
endpackage

// File: rtl/cfg_alu_shift.sv
module cfg_alu_shift
  import cfg_alu_pkg::*;
#(
  parameter int W = 64,
  localparam int SW = $clog2(W)
) (
  input  logic [W-1:0]  a_i,
  input  logic [SW-1:0] amt_i,
  input  shift_kind_e   kind_i,
  output logic [W-1:0]  y_o
);
  logic [W-1:0]   src, rev_a, rev_y, core;
  logic [2*W-1:0] ext;
  logic           fill;

  always_comb begin
    for (int i = 0; i < W; i++) rev_a[i] = a_i[W-1-i];
  end

  // left shift reuses the right shifter on the bit-reversed operand
  assign src  = (kind_i == SK_LEFT) ? rev_a : a_i;
  assign fill = (kind_i == SK_RARI) & a_i[W-1];
  assign ext  = {{W{fill}}, src} >> amt_i;
  assign core = ext[W-1:0];

  always_comb begin
    for (int i = 0; i < W; i++) rev_y[i] = core[W-1-i];
  end

  assign y_o = (kind_i == SK_LEFT) ? rev_y : core;
endmodule

// File: rtl/cfg_alu_mul.sv
module cfg_alu_mul #(
  parameter int W = 64,
  parameter int STAGES = 4,
  localparam int CH = W / STAGES
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         v_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic         v_o,
  output logic [W-1:0] p_o
);
  initial begin
    assert (W % STAGES == 0) else $error("operand width must divide into stages");
  end

  for (genvar k = 0; k <= STAGES; k++) begin : g_stg
    logic         v;
    logic [W-1:0] a, b, acc;
    if (k == 0) begin : g_in
      assign v   = v_i;
      assign a   = a_i;
      assign b   = b_i;
      assign acc = '0;
    end else begin : g_reg
      // stage k folds in the partial product of chunk k-1 of b
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          v <= 1'b0; a <= '0; b <= '0; acc <= '0;
        end else begin
          v   <= g_stg[k-1].v;
          a   <= g_stg[k-1].a;
          b   <= g_stg[k-1].b;
          acc <= g_stg[k-1].acc
               + ((g_stg[k-1].a * W'(g_stg[k-1].b[(k-1)*CH +: CH])) << ((k-1)*CH));
        end
      end

      AST_STAGE_MOVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        g_stg[k-1].v |=> v); // R6
    end
  end

  assign v_o = g_stg[STAGES].v;
  assign p_o = g_stg[STAGES].acc;
endmodule

// File: rtl/cfg_alu.sv
module cfg_alu
  import cfg_alu_pkg::*;
#(
  parameter int         WIDTH      = 64,
  parameter int         ADD_W      = 64,
  parameter logic [7:0] OP_MASK    = 8'hFF,
  parameter int         MUL_STAGES = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [3:0]       op_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic             valid_o,
  output logic [WIDTH-1:0] result_o
);
  localparam int         SW       = $clog2(WIDTH);
  localparam bit         EN_ADD   = OP_MASK[0];
  localparam bit         EN_AND   = OP_MASK[1];
  localparam bit         EN_OR    = OP_MASK[2];
  localparam bit         EN_XOR   = OP_MASK[3];
  localparam bit         EN_SHL   = OP_MASK[4];
  localparam bit         EN_SHR   = OP_MASK[5];
  localparam bit         EN_SRA   = OP_MASK[6];
  localparam bit         EN_MUL   = OP_MASK[7];
  localparam bit         EN_SHIFT = EN_SHL | EN_SHR | EN_SRA;
  localparam logic [WIDTH-1:0] ADD_MASK = {WIDTH{1'b1}} >> (WIDTH - ADD_W);

  logic             v_q;
  logic [3:0]       op_q;
  logic [WIDTH-1:0] a_q, b_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_q <= 1'b0; op_q <= '0; a_q <= '0; b_q <= '0;
    end else begin
      v_q  <= valid_i;
      op_q <= op_i;
      a_q  <= a_i;
      b_q  <= b_i;
    end
  end

  logic mul_go;
  assign mul_go = v_q && (op_q == OP_MUL) && EN_MUL;

  logic             mul_v;
  logic [WIDTH-1:0] mul_p;

  if (EN_MUL) begin : g_mul
    cfg_alu_mul #(.W(WIDTH), .STAGES(MUL_STAGES)) u_mul (
      .clk_i(clk_i), .rst_ni(rst_ni), .v_i(mul_go),
      .a_i(a_q), .b_i(b_q), .v_o(mul_v), .p_o(mul_p)
    );
  end else begin : g_no_mul
    assign mul_v = 1'b0;
    assign mul_p = '0;
  end

  logic [WIDTH-1:0] shift_y;
  shift_kind_e      shift_kind;

  always_comb begin
    unique case (op_q)
      OP_SHL:  shift_kind = SK_LEFT;
      OP_SRA:  shift_kind = SK_RARI;
      default: shift_kind = SK_RLOG;
    endcase
  end

  if (EN_SHIFT) begin : g_shift
    cfg_alu_shift #(.W(WIDTH)) u_shift (
      .a_i(a_q), .amt_i(b_q[SW-1:0]), .kind_i(shift_kind), .y_o(shift_y)
    );
  end else begin : g_no_shift
    assign shift_y = '0;
  end

  logic [WIDTH-1:0] add_y, fast_y;
  assign add_y = (a_q + b_q) & ADD_MASK;

  always_comb begin
    case (op_q)
      OP_ADD:  fast_y = EN_ADD ? add_y : '0;
      OP_AND:  fast_y = EN_AND ? (a_q & b_q) : '0;
      OP_OR:   fast_y = EN_OR  ? (a_q | b_q) : '0;
      OP_XOR:  fast_y = EN_XOR ? (a_q ^ b_q) : '0;
      OP_SHL:  fast_y = EN_SHL ? shift_y : '0;
      OP_SHR:  fast_y = EN_SHR ? shift_y : '0;
      OP_SRA:  fast_y = EN_SRA ? shift_y : '0;
      default: fast_y = '0;
    endcase
  end

  // multiply wins a collision at the output register
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      result_o <= '0;
    end else if (mul_v) begin
      valid_o  <= 1'b1;
      result_o <= mul_p;
    end else if (v_q && !mul_go) begin
      valid_o  <= 1'b1;
      result_o <= fast_y;
    end else begin
      valid_o  <= 1'b0;
    end
  end

  AST_ISSUE_LAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (v_q && !mul_go) |=> valid_o); // R1

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!v_q && !mul_v) |=> !valid_o); // R10

  AST_DROP_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (v_q && !mul_v && (op_q > 4'd7 || !OP_MASK[op_q[2:0]])) |=> (result_o == '0)); // R7

  AST_SHR_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (v_q && !mul_v && op_q == OP_SHR && EN_SHR) |=> (result_o <= $past(a_q))); // R4

  AST_SRA_SIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (v_q && !mul_v && op_q == OP_SRA && EN_SRA) |=> (result_o[WIDTH-1] == $past(a_q[WIDTH-1]))); // R5
endmodule

// File: tb/cfg_alu_test.sv
module cfg_alu_test;
  localparam int W = 8;
  localparam int AW = 4;
  localparam int ST = 4;
  localparam logic [7:0] MASK = 8'hF7;  // XOR left out

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         valid_i = 1'b0;
  logic [3:0]   op_i = '0;
  logic [W-1:0] a_i = '0, b_i = '0;
  logic         valid_o;
  logic [W-1:0] result_o;

  int checks = 0;
  int errors = 0;

  logic         exp_v [16];
  logic [W-1:0] exp_d [16];
  string        exp_t [16];
  int           cyc = 0;

  always #4 clk = ~clk;

  cfg_alu #(.WIDTH(W), .ADD_W(AW), .OP_MASK(MASK), .MUL_STAGES(ST)) uut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .op_i(op_i),
    .a_i(a_i), .b_i(b_i), .valid_o(valid_o), .result_o(result_o)
  );

  function automatic logic [W-1:0] model(input logic [3:0] op, input logic [W-1:0] a, b);
    case (op)
      4'd0: model = (a + b) & W'((1 << AW) - 1);
      4'd1: model = a & b;
      4'd2: model = a | b;
      4'd4: model = a << b[2:0];
      4'd5: model = a >> b[2:0];
      4'd6: model = W'($signed(a) >>> b[2:0]);
      4'd7: model = a * b;
      default: model = '0;  // XOR disabled, 8..15 unused
    endcase
  endfunction

  function automatic string tag_of(input logic [3:0] op);
    case (op)
      4'd0: tag_of = "R2";
      4'd1, 4'd2: tag_of = "R3";
      4'd4, 4'd5: tag_of = "R4";
      4'd6: tag_of = "R5";
      4'd7: tag_of = "R6";
      default: tag_of = "R7";
    endcase
  endfunction

  task automatic clear_slots();
    for (int i = 0; i < 16; i++) begin
      exp_v[i] = 1'b0; exp_d[i] = '0; exp_t[i] = "R10";
    end
  endtask

  // one cycle: check what is due now, then drive the next issue
  task automatic step(input logic v, input logic [3:0] op, input logic [W-1:0] a, b,
                      input string force_tag = "");
    int s, d;
    @(negedge clk);
    s = cyc % 16;
    checks++;
    if (valid_o !== exp_v[s] || (exp_v[s] && result_o !== exp_d[s])) begin
      errors++;
      $display("FAIL %s: cycle %0d valid=%b result=%h expected valid=%b result=%h",
               exp_t[s], cyc, valid_o, result_o, exp_v[s], exp_d[s]);
    end
    exp_v[s] = 1'b0; exp_t[s] = "R10";
    valid_i = v; op_i = op; a_i = a; b_i = b;
    if (v && rst_n) begin
      if (op == 4'd7) begin
        d = (cyc + ST + 2) % 16;
        exp_v[d] = 1'b1; exp_d[d] = model(op, a, b);
        exp_t[d] = (force_tag != "") ? force_tag : "R6";
      end else begin
        d = (cyc + 2) % 16;
        if (exp_v[d]) exp_t[d] = "R8";  // multiply already owns that slot
        else begin
          exp_v[d] = 1'b1; exp_d[d] = model(op, a, b);
          exp_t[d] = (force_tag != "") ? force_tag : tag_of(op);
        end
      end
    end
    cyc++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 4'(i), W'(i * 37), W'(i * 11));
  endtask

  initial begin
    logic [15:0] lfsr;
    clear_slots();
    // R9: outputs held at zero in reset
    repeat (3) @(negedge clk);
    checks++;
    if (valid_o !== 1'b0 || result_o !== '0) begin
      errors++;
      $display("FAIL R9: reset valid=%b result=%h expected valid=0 result=00", valid_o, result_o);
    end
    rst_n = 1'b1;
    // R10: noise on data lines without valid_i
    idle(10);
    // R1: isolated issue, valid exactly two edges later
    step(1'b1, 4'd1, 8'hF0, 8'h3C, "R1");
    idle(4);
    // sweep all opcodes over every A and a spread of B
    for (int op = 0; op < 16; op++) begin
      for (int a = 0; a < 256; a++)
        for (int b = 0; b < 256; b += 17)
          step(1'b1, 4'(op), W'(a), W'(b ^ (a >> 3)));
      idle(ST + 3);
    end
    // R8: multiply followed four cycles later by a fast op collides
    step(1'b1, 4'd7, 8'h13, 8'h07);
    idle(3);
    step(1'b1, 4'd2, 8'h55, 8'hAA);
    idle(ST + 3);
    // mixed streams with collisions
    lfsr = 16'hACE1;
    for (int i = 0; i < 6000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[0] | lfsr[5], lfsr[4:1], lfsr[15:8], lfsr[11:4]);
    end
    idle(ST + 3);
    // R9: reset in the middle of traffic
    step(1'b1, 4'd7, 8'h21, 8'h05);
    step(1'b1, 4'd0, 8'h09, 8'h08);
    @(negedge clk);
    rst_n = 1'b0; valid_i = 1'b0;
    @(negedge clk);
    checks++;
    if (valid_o !== 1'b0 || result_o !== '0) begin
      errors++;
      $display("FAIL R9: mid-run reset valid=%b result=%h expected valid=0 result=00",
               valid_o, result_o);
    end
    clear_slots();
    @(negedge clk);
    rst_n = 1'b1;
    idle(ST + 4);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(150000 * 8);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule